// File: doc/BRIEF.md
# External DMA Request Handshake Controller

This block runs single DMA transfers between an on-chip bus and an external device. The external device raises a request pin. The block passes that pin through a synchronizer and can treat it as level-sensitive or edge-sensitive, with either polarity. Once a request is seen, the block asks an on-chip arbiter for the bus. When the grant arrives, it drives an active-low acknowledge for exactly one bus cycle.

While acknowledge is low, the block drives the external read strobe or the write strobes, according to the programmed direction and size. A write moves data from memory to the device. A word write drives both the upper and lower write strobes; a byte write drives only the lower one. A configuration bit can keep the external chip-select inactive for the whole DMA cycle.

The bus cycle lasts a programmed number of clocks. The bus request is dropped in the same clock that acknowledge returns high. Configuration is written through a single write port and should be changed only while no transfer is in progress.

Top module: `ext_dma_handshake`

## Requirements
- R1: After reset: busReq is 0; dackN, csN, rdN, wruN and wrlN are all 1; the configuration register is all zeros, which selects a level-sensitive, active-low request.
- R2: With the default two synchronizer stages and busGnt already high, busReq rises at the 3rd rising clock edge after reqPin becomes active in level mode and at the 4th in edge mode. dackN falls one edge after busReq rises.
- R3: A polarity bit of 1 makes a high reqPin the active request level; a 0 makes a low reqPin active.
- R4: dackN never falls without a grant. While busGnt stays low, busReq stays high and dackN stays high. dackN falls at the first rising edge that samples busGnt high.
- R5: dackN stays low for exactly wait+1 clocks, where wait is the programmed wait count. busReq falls in the same clock that dackN rises.
- R6: In level mode, a request held active without a break gives transfers separated by exactly 3 clocks of dackN high. This holds with the grant held high, and acknowledge is never low in the clock right after it rises.
- R7: In edge mode, one active edge produces exactly one transfer, even if the level stays active afterwards. An edge that arrives while a transfer is running is remembered and produces exactly one more transfer.
- R8: In a write cycle (direction bit 1), wrlN is low for the whole acknowledge. wruN is also low if the size bit is 1 (word) and stays high if the size bit is 0 (byte). rdN stays high.
- R9: In a read cycle (direction bit 0), rdN is low for the whole acknowledge and both write strobes stay high.
- R10: csN is low exactly while dackN is low, unless the chip-select-off bit is 1. In that case csN stays high for the whole cycle.
- R11: When cfgWe is 1 at a rising edge, the configuration register loads cfgWrData, with these bit positions:
  - bit 0: edge mode
  - bit 1: polarity
  - bit 2: direction
  - bit 3: size
  - bit 4: chip-select off
  - bits 8:5: wait count

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration register write enable |
| cfgWrData | input | 9 | Configuration value (field layout in R11) |
| reqPin | input | 1 | Asynchronous external DMA request |
| busGnt | input | 1 | Bus grant from the arbiter |
| busReq | output | 1 | Bus request to the arbiter |
| dackN | output | 1 | Active-low DMA acknowledge |
| csN | output | 1 | Active-low external chip-select during DMA |
| rdN | output | 1 | Active-low read strobe |
| wruN | output | 1 | Active-low upper-byte write strobe |
| wrlN | output | 1 | Active-low lower-byte write strobe |

## Verification
Two events can fall in the same clock.

The first pair is the end of the bus cycle and the release of the bus request. Every transfer provokes this pair. It is judged by sampling busReq in the first clock that dackN is high again.

The second pair is a new request edge and the clearing of the pending edge flag. An edge is injected while acknowledge is low. The block must produce exactly one further transfer, neither losing the edge nor duplicating it.

// File: rtl/xdh_pkg.sv
package xdh_pkg;

  // Bit positions inside the configuration word.
  localparam int CFG_EDGE     = 0;
  localparam int CFG_POLHI    = 1;
  localparam int CFG_DIRWR    = 2;
  localparam int CFG_WORD     = 3;
  localparam int CFG_CSOFF    = 4;
  localparam int CFG_WAIT_LSB = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CYC  = 2'd2,
    ST_GAP  = 2'd3
  } xdh_state_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic ackOn;
    logic pendClr;
    logic cntLoad;
    logic cntDec;
  } xdh_strb_t;

  // Status from the datapath to the control.
  typedef struct packed {
    logic trigger;
    logic cntZero;
  } xdh_stat_t;

endpackage

// File: rtl/xdh_datapath.sv
module xdh_datapath
  import xdh_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_W      = 4,
  localparam int CFG_W      = CFG_WAIT_LSB + WAIT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             reqPin,
  input  xdh_strb_t        strb,
  output xdh_stat_t        stat,
  output logic             dackN,
  output logic             csN,
  output logic             rdN,
  output logic             wruN,
  output logic             wrlN
);

  logic [CFG_W-1:0]       cfgReg;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   reqAct;
  logic                   prevAct;
  logic                   edgeNow;
  logic                   pending;
  logic [WAIT_W-1:0]      waitCnt;

  logic cfgEdge;
  logic cfgDirWr;
  logic cfgWord;
  logic cfgCsOff;

  assign cfgEdge  = cfgReg[CFG_EDGE];
  assign cfgDirWr = cfgReg[CFG_DIRWR];
  assign cfgWord  = cfgReg[CFG_WORD];
  assign cfgCsOff = cfgReg[CFG_CSOFF];

  // Configuration register; all zeros means level mode, active low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgWrData;
  end

  // Synchronizer chain for the request pin.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= reqPin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  // Normalise the request to active-high, then detect the active edge.
  assign reqAct  = (syncQ[SYNC_STAGES-1] == cfgReg[CFG_POLHI]);
  assign edgeNow = reqAct & ~prevAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAct <= 1'b0;
    else       prevAct <= reqAct;
  end

  // A new edge wins over the clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pending <= 1'b0;
    else if (edgeNow && cfgEdge) pending <= 1'b1;
    else if (strb.pendClr)       pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             waitCnt <= '0;
    else if (strb.cntLoad) waitCnt <= cfgReg[CFG_W-1:CFG_WAIT_LSB];
    else if (strb.cntDec)  waitCnt <= waitCnt - 1'b1;
  end

  assign stat.trigger = cfgEdge ? pending : reqAct;
  assign stat.cntZero = (waitCnt == '0);

  // Pin decode.
  assign dackN = ~strb.ackOn;
  assign csN   = ~(strb.ackOn & ~cfgCsOff);
  assign rdN   = ~(strb.ackOn & ~cfgDirWr);
  assign wrlN  = ~(strb.ackOn & cfgDirWr);
  assign wruN  = ~(strb.ackOn & cfgDirWr & cfgWord);

  a_r8_upper_needs_lower: assert property (@(posedge clk) disable iff (!rstN)
    !wruN |-> !wrlN);

  a_r9_read_excludes_write: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (wrlN && wruN));

  a_r10_cs_only_in_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !dackN);

  a_r7_pending_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pendClr && !(edgeNow && cfgEdge)) |=> !pending);

  a_r5_count_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntDec |-> !stat.cntZero);

endmodule

// File: rtl/xdh_ctrl.sv
module xdh_ctrl
  import xdh_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  xdh_stat_t stat,
  input  logic      busGnt,
  output xdh_strb_t strb,
  output logic      busReq
);

  xdh_state_e state;
  xdh_state_e stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (stat.trigger) stateNext = ST_REQ;
      ST_REQ:  if (busGnt)       stateNext = ST_CYC;
      ST_CYC:  if (stat.cntZero) stateNext = ST_GAP;
      ST_GAP:                    stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  // The request covers the grant wait and the bus cycle; it drops with acknowledge.
  assign busReq       = (state == ST_REQ) || (state == ST_CYC);
  assign strb.ackOn   = (state == ST_CYC);
  assign strb.cntLoad = (state == ST_REQ) && busGnt;
  assign strb.pendClr = (state == ST_REQ) && busGnt;
  assign strb.cntDec  = (state == ST_CYC) && !stat.cntZero;

  a_r4_ack_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackOn && !$past(strb.ackOn)) |-> $past(busGnt));

  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt && !strb.ackOn) |=> (busReq && !strb.ackOn));

  a_r5_release_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.ackOn) |-> !busReq);

  a_r6_gap_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.ackOn) |=> !strb.ackOn);

endmodule

// File: rtl/ext_dma_handshake.sv
module ext_dma_handshake
  import xdh_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_W      = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWe,
  input  logic [CFG_WAIT_LSB+WAIT_W-1:0] cfgWrData,
  input  logic                           reqPin,
  input  logic                           busGnt,
  output logic                           busReq,
  output logic                           dackN,
  output logic                           csN,
  output logic                           rdN,
  output logic                           wruN,
  output logic                           wrlN
);

  xdh_strb_t strb;
  xdh_stat_t stat;

  xdh_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .busGnt (busGnt),
    .strb   (strb),
    .busReq (busReq)
  );

  xdh_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .WAIT_W      (WAIT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgWrData (cfgWrData),
    .reqPin    (reqPin),
    .strb      (strb),
    .stat      (stat),
    .dackN     (dackN),
    .csN       (csN),
    .rdN       (rdN),
    .wruN      (wruN),
    .wrlN      (wrlN)
  );

endmodule

// File: tb/sim_ext_dma_handshake.sv
`timescale 1ns/1ps
module sim_ext_dma_handshake;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [8:0] cfgWrData = '0;
  logic       reqPin = 1'b1;
  logic       busGnt = 1'b0;
  logic       busReq, dackN, csN, rdN, wruN, wrlN;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  ext_dma_handshake u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWrData(cfgWrData),
    .reqPin(reqPin), .busGnt(busGnt), .busReq(busReq), .dackN(dackN),
    .csN(csN), .rdN(rdN), .wruN(wruN), .wrlN(wrlN)
  );

  typedef struct packed {
    logic       edgeM;
    logic       polHi;
    logic       dirWr;
    logic       word;
    logic       csOff;
    logic [3:0] waitC;
    logic       expWru;
    logic       expWrl;
    logic       expRd;
    logic       expCs;
    logic [3:0] expLen;
    logic [3:0] expLat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 4'd3},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd3},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 4'd3},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4, 4'd4},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 4'd4},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6, 4'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [8:0] val);
    cfgWrData = val;
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Counts negedges until busReq is seen high (at most lim).
  task automatic waitBusReq(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!busReq && n < lim);
  endtask

  task automatic waitDack(input logic lvl, input int lim, output int n);
    n = 0;
    while (dackN !== lvl && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runVec(input vec_t v);
    int n, len;
    bit badWr, badRd, badCs;
    reqPin = v.polHi ? 1'b0 : 1'b1;
    repeat (20) @(negedge clk);
    writeCfg({v.waitC, v.csOff, v.word, v.dirWr, v.polHi, v.edgeM});
    repeat (16) @(negedge clk);
    reqPin = v.polHi ? 1'b1 : 1'b0;
    waitBusReq(20, n);
    chk(n == int'(v.expLat), "R2 R3 R11 request latency", n, v.expLat);
    @(negedge clk);
    chk(dackN == 1'b0, "R4 ack one clock after request with grant", dackN, 0);
    reqPin = v.polHi ? 1'b0 : 1'b1;
    len = 0; badWr = 0; badRd = 0; badCs = 0;
    while (dackN == 1'b0 && len < 20) begin
      if (wruN !== v.expWru || wrlN !== v.expWrl) badWr = 1;
      if (rdN !== v.expRd) badRd = 1;
      if (csN !== v.expCs) badCs = 1;
      len++;
      @(negedge clk);
    end
    chk(len == int'(v.expLen), "R5 ack length wait+1", len, v.expLen);
    chk(busReq == 1'b0, "R5 busReq released with ack", busReq, 0);
    chk(!badWr, "R8 write strobes", {wruN, wrlN}, {v.expWru, v.expWrl});
    chk(!badRd, "R9 read strobe", badRd, 0);
    chk(!badCs, "R10 chip-select", badCs, 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    int n, cnt;
    bit bad;
    logic prevD;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busReq, dackN, csN, rdN, wruN, wrlN} == 6'b011111, "R1 outputs in reset",
        {busReq, dackN, csN, rdN, wruN, wrlN}, 6'b011111);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk({busReq, dackN, csN, rdN, wruN, wrlN} == 6'b011111, "R1 outputs after reset",
        {busReq, dackN, csN, rdN, wruN, wrlN}, 6'b011111);

    // R1 default config: level, active low
    busGnt = 1'b1;
    reqPin = 1'b0;
    waitBusReq(20, n);
    chk(n == 3, "R1 R2 default level active-low latency", n, 3);
    @(negedge clk);
    chk(dackN == 1'b0, "R1 default transfer ack", dackN, 0);
    reqPin = 1'b1;
    repeat (20) @(negedge clk);

    // R4 grant wait
    busGnt = 1'b0;
    reqPin = 1'b0;
    waitBusReq(20, n);
    reqPin = 1'b1;
    bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (!busReq || !dackN) bad = 1;
    end
    chk(!bad, "R4 hold request without ack while no grant", bad, 0);
    busGnt = 1'b1;
    @(negedge clk);
    chk(dackN == 1'b0, "R4 ack on grant", dackN, 0);
    repeat (20) @(negedge clk);

    // R6 level mode held request
    reqPin = 1'b0;
    waitDack(1'b0, 20, n);
    waitDack(1'b1, 20, n);
    waitDack(1'b0, 20, n);
    chk(n == 3, "R6 clocks between level transfers", n, 3);
    reqPin = 1'b1;
    repeat (20) @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) runVec(VEC[i]);

    // R7 edge mode: one edge, one transfer
    reqPin = 1'b1;
    repeat (20) @(negedge clk);
    writeCfg({4'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1});
    repeat (6) @(negedge clk);
    reqPin = 1'b0;
    cnt = 0; prevD = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (prevD && !dackN) cnt++;
      prevD = dackN;
    end
    chk(cnt == 1, "R7 one transfer per edge", cnt, 1);
    reqPin = 1'b1;
    repeat (10) @(negedge clk);

    // R7 edge arriving during a transfer
    writeCfg({4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1});
    repeat (6) @(negedge clk);
    reqPin = 1'b0;
    waitDack(1'b0, 20, n);
    reqPin = 1'b1;
    repeat (3) @(negedge clk);
    reqPin = 1'b0;
    cnt = 1; prevD = dackN;
    repeat (50) begin
      @(negedge clk);
      if (prevD && !dackN) cnt++;
      prevD = dackN;
    end
    chk(cnt == 2, "R7 edge during cycle gives one more transfer", cnt, 2);
    chk(busReq == 1'b0 && dackN == 1'b1, "R5 idle after transfers", busReq, 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule